// File: doc/BRIEF.md
# USB Endpoint Double-Bank Buffer Manager

This block owns the packet buffer memory of a full-speed USB device function that has four endpoints. All endpoint buffers sit in one 328-byte dual-port RAM. The serial side (the packet engine) uses one RAM port and the firmware side uses the other. Each endpoint has a fixed size and a fixed address region. Endpoint 0 has 8 bytes and endpoint 3 has 64 bytes. Endpoints 1 and 2 each have two 64-byte banks, which are used alternately. This double banking suits bulk and isochronous traffic, because one bank can be on the wire while the firmware works on the other.

Every bank belongs to exactly one side at a time. The side that owns a bank can write bytes to it as a FIFO. Each accepted write appends a byte and increments the bank's count. The owning side can also read the bank sequentially from offset 0. When the side finishes, it hands the bank over: the serial side with `usb_done`, the firmware with `cpu_release`. The count survives the handover if the handing side wrote data. If the handing side only drained the bank, the count is cleared. On a double-bank endpoint, each side then moves on to the other bank. A side that does not own its current bank is refused: the serial side sees `usb_nak` and the firmware sees `cpu_ready` low.

Top module: `epbuf_top`

## Requirements
- R1: The fixed regions are: endpoint 0 at bytes 0-7; endpoint 1 at 8-71 (bank 0) and 72-135 (bank 1); endpoint 2 at 136-199 (bank 0) and 200-263 (bank 1); endpoint 3 at 264-327. Filling every bank to its size and reading every bank back returns each bank's own data.
- R2: After reset, all counts are 0 and each endpoint's banks are owned by the serial side. The exception is an endpoint whose bit is set in parameter `IN_MASK` (default 4'b1000, endpoint 3): its banks start with the firmware. `usb_nak` therefore reads 0,0,0,1 for endpoints 0..3, and `cpu_ready` reads 0,0,0,1.
- R3: A write to a bank that already holds its size in bytes is dropped. The count stays at the size and the overflow flag of that bank (`usb_ovf` or `cpu_ovf`) is set. The handover clears the flag.
- R4: `usb_done` passes the serial side's current bank to the firmware with its count unchanged. The firmware then sees `cpu_ready`=1 and `cpu_count` equal to the bytes written.
- R5: On endpoints 1 and 2, after a completion the serial side moves to the other bank and can fill it while the firmware holds the first. Once both banks are with the firmware, `usb_nak`=1 until a bank is released.
- R6: On endpoints 0 and 3, after a handover the handing side is refused until the other side hands the bank back.
- R7: A handover by a side that wrote no byte during its ownership clears the count to 0. A handover by a side that wrote keeps the count.
- R8: A write, read or handover from a side that does not own its current bank has no effect on data, count or ownership.
- R9: A read strobe returns the byte at the side's read offset on `*_rdata` one cycle later. The offset starts at 0 and advances by one per read, up to the count.
- R10: The firmware visits the banks of a double-bank endpoint in the order the serial side completed them.
- R11: A write or read issued in the same cycle as that side's handover is ignored. The handed-over count excludes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| usb_ep | input | 2 | Endpoint addressed by the serial side |
| usb_wr | input | 1 | Serial side byte write strobe |
| usb_rd | input | 1 | Serial side byte read strobe |
| usb_wdata | input | 8 | Serial side write byte |
| usb_done | input | 1 | Serial side hands its current bank over |
| usb_rdata | output | 8 | Serial side read byte, one cycle after the strobe |
| usb_nak | output | 1 | Serial side does not own the current bank |
| usb_count | output | 7 | Byte count of the serial side's current bank |
| usb_ovf | output | 1 | Overflow flag of the serial side's current bank |
| cpu_ep | input | 2 | Endpoint addressed by the firmware |
| cpu_wr | input | 1 | Firmware byte write strobe |
| cpu_rd | input | 1 | Firmware byte read strobe |
| cpu_wdata | input | 8 | Firmware write byte |
| cpu_release | input | 1 | Firmware hands its current bank over |
| cpu_rdata | output | 8 | Firmware read byte, one cycle after the strobe |
| cpu_ready | output | 1 | Firmware owns the current bank |
| cpu_count | output | 7 | Byte count of the firmware's current bank |
| cpu_ovf | output | 1 | Overflow flag of the firmware's current bank |

## Verification
The bench targets these corner cases:
- **Full memory.** It fills every bank to the brim before reading anything back. A wrong base address or bank pointer would show up as a neighbour's bytes.
- **Double-bank limit.** It completes both banks of endpoint 1. A design that rotated banks without regard to ownership would accept data into a firmware-held bank instead of answering NAK.
- **Handover count rule.** It follows a firmware-filled endpoint 3 packet through to the serial side and back. A design that always cleared or always kept the count would report the wrong length on one leg.
- **Overflow and same-cycle strobes.** Writes beyond the size and writes in the same cycle as a handover must leave the count and data untouched. A design that wrapped the offset would corrupt byte 0.

// File: rtl/epbuf_pkg.sv
// Shared constants and bank map helpers for the endpoint buffer manager.
// Assumes six banks: one for endpoint 0, two each for endpoints 1 and 2,
// one for endpoint 3, packed back to back in that order.
package epbuf_pkg;
    localparam int NUM_EP     = 4;
    localparam int NUM_BANK   = 6;
    localparam int DATA_W     = 8;
    localparam int EP0_BYTES  = 8;
    localparam int PP_BYTES   = 64;
    localparam int EP3_BYTES  = 64;
    localparam int MAX_BYTES  = 64;
    localparam int MEM_BYTES  = EP0_BYTES + 4 * PP_BYTES + EP3_BYTES;
    localparam int ADDR_W     = $clog2(MEM_BYTES);
    localparam int CNT_W      = $clog2(MAX_BYTES + 1);
    localparam int BANK_W     = $clog2(NUM_BANK);
    localparam int EP_W       = $clog2(NUM_EP);

    // endpoint has two alternating banks
    function automatic bit ep_double(input int ep);
        return (ep == 1) || (ep == 2);
    endfunction

    // bank index for an endpoint and its bank pointer
    function automatic logic [BANK_W-1:0] bank_of(input logic [EP_W-1:0] ep, input logic pp);
        case (ep)
            2'd0:    return BANK_W'(0);
            2'd1:    return BANK_W'(1) + BANK_W'(pp);
            2'd2:    return BANK_W'(3) + BANK_W'(pp);
            default: return BANK_W'(5);
        endcase
    endfunction

    // endpoint that a bank belongs to
    function automatic int ep_of_bank(input int b);
        if (b == 0) return 0;
        if (b <= 2) return 1;
        if (b <= 4) return 2;
        return 3;
    endfunction

    // size of a bank in bytes
    function automatic int bank_size(input int b);
        if (b == 0) return EP0_BYTES;
        if (b == NUM_BANK - 1) return EP3_BYTES;
        return PP_BYTES;
    endfunction

    // first RAM address of a bank
    function automatic logic [ADDR_W-1:0] bank_base(input logic [BANK_W-1:0] b);
        case (b)
            3'd0:             return ADDR_W'(0);
            3'd1, 3'd2,
            3'd3, 3'd4:       return ADDR_W'(EP0_BYTES + (int'(b) - 1) * PP_BYTES);
            default:          return ADDR_W'(EP0_BYTES + 4 * PP_BYTES);
        endcase
    endfunction
endpackage

// File: rtl/epbuf_ram.sv
// Two-port byte RAM with registered read on each port.
// Assumes the two ports never write the same address in one cycle;
// ownership in the manager guarantees this. Port B wins if they do.
module epbuf_ram #(
    parameter int DEPTH = 328,
    parameter int AW    = 9,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata
);
    logic [DW-1:0] mem [DEPTH];

    // write both ports and register both read words
    always_ff @(posedge clk) begin
        if (a_we) mem[a_addr] <= a_wdata;
        if (b_we) mem[b_addr] <= b_wdata;
        a_rdata <= mem[a_addr];
        b_rdata <= mem[b_addr];
    end
endmodule

// File: rtl/epbuf_bank.sv
// State of one buffer bank: owning side, byte count, read offset,
// overflow flag and whether the owner wrote since it took the bank.
// Assumes event inputs come only from the side that owns the bank.
module epbuf_bank
    import epbuf_pkg::*;
#(
    parameter int SIZE    = 64,
    parameter bit RST_CPU = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             rd,
    input  logic             hand,
    output logic             owner_cpu,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] rdptr,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] SIZE_C = CNT_W'(SIZE);
    logic wrote;

    // ownership, count and offsets of this bank
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_cpu <= RST_CPU;
            count     <= '0;
            rdptr     <= '0;
            ovf       <= 1'b0;
            wrote     <= 1'b0;
        end else if (hand) begin
            owner_cpu <= ~owner_cpu;
            rdptr     <= '0;
            ovf       <= 1'b0;
            wrote     <= 1'b0;
            if (!wrote) count <= '0;
        end else begin
            if (wr) begin
                if (count < SIZE_C) begin
                    count <= count + 1'b1;
                    wrote <= 1'b1;
                end else begin
                    ovf <= 1'b1;
                end
            end
            if (rd && (rdptr < count)) rdptr <= rdptr + 1'b1;
        end
    end

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= SIZE_C);
    assert_ovf_only_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(count) == SIZE_C);
    assert_hand_flips_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hand |=> owner_cpu != $past(owner_cpu));
    assert_drain_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hand && !wrote) |=> count == '0);
    assert_rdptr_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rdptr <= count);
endmodule

// File: rtl/epbuf_port.sv
// One access side (serial or firmware). It keeps the side's bank pointer
// for double-bank endpoints, decides ownership of the addressed bank and
// turns strobes into per-bank events and a RAM port request.
// Assumes bank state vectors come from the bank instances.
module epbuf_port
    import epbuf_pkg::*;
#(
    parameter bit SIDE_CPU = 1'b0
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [EP_W-1:0]                   ep,
    input  logic                              wr,
    input  logic                              rd,
    input  logic                              hand,
    input  logic [NUM_BANK-1:0]               bank_cpu,
    input  logic [NUM_BANK-1:0][CNT_W-1:0]    bank_cnt,
    input  logic [NUM_BANK-1:0][CNT_W-1:0]    bank_rdp,
    input  logic [NUM_BANK-1:0]               bank_ovf,
    output logic                              owns,
    output logic [BANK_W-1:0]                 sel_bank,
    output logic [CNT_W-1:0]                  sel_cnt,
    output logic                              sel_ovf,
    output logic [NUM_BANK-1:0]               wr_v,
    output logic [NUM_BANK-1:0]               rd_v,
    output logic [NUM_BANK-1:0]               hand_v,
    output logic                              ram_we,
    output logic [ADDR_W-1:0]                 ram_addr
);
    logic [NUM_EP-1:0] pp_q;
    logic              wr_ok, rd_ok, hand_ok;
    logic [CNT_W-1:0]  sel_rdp;

    // per-endpoint bank pointer: toggles on own handover for double banks
    for (genvar e = 0; e < NUM_EP; e++) begin : g_pp
        if (ep_double(e)) begin : g_dbl
            always_ff @(posedge clk) begin
                if (!rst_n)                               pp_q[e] <= 1'b0;
                else if (hand_ok && (ep == EP_W'(e)))     pp_q[e] <= ~pp_q[e];
            end
        end else begin : g_sgl
            assign pp_q[e] = 1'b0;
        end
    end

    // select bank, check ownership and qualify strobes
    always_comb begin
        sel_bank = bank_of(ep, pp_q[ep]);
        owns     = (bank_cpu[sel_bank] == SIDE_CPU);
        sel_cnt  = bank_cnt[sel_bank];
        sel_rdp  = bank_rdp[sel_bank];
        sel_ovf  = bank_ovf[sel_bank];
        hand_ok  = owns && hand;
        wr_ok    = owns && wr && !hand;
        rd_ok    = owns && rd && !wr && !hand;
        wr_v     = '0;
        rd_v     = '0;
        hand_v   = '0;
        wr_v[sel_bank]   = wr_ok;
        rd_v[sel_bank]   = rd_ok;
        hand_v[sel_bank] = hand_ok;
        ram_we   = wr_ok && (int'(sel_cnt) < bank_size(int'(sel_bank)));
        ram_addr = bank_base(sel_bank) + ADDR_W'(wr_ok ? sel_cnt : sel_rdp);
    end

    assert_refused_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !owns |-> (wr_v == '0) && (rd_v == '0) && (hand_v == '0) && !ram_we);
endmodule

// File: rtl/epbuf_top.sv
// Endpoint buffer manager top: six bank state blocks, one access side
// for the serial engine and one for the firmware, and the shared
// two-port RAM. Assumes IN_MASK marks endpoints whose banks start
// with the firmware.
module epbuf_top
    import epbuf_pkg::*;
#(
    parameter logic [3:0] IN_MASK = 4'b1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  usb_ep,
    input  logic        usb_wr,
    input  logic        usb_rd,
    input  logic [7:0]  usb_wdata,
    input  logic        usb_done,
    output logic [7:0]  usb_rdata,
    output logic        usb_nak,
    output logic [6:0]  usb_count,
    output logic        usb_ovf,
    input  logic [1:0]  cpu_ep,
    input  logic        cpu_wr,
    input  logic        cpu_rd,
    input  logic [7:0]  cpu_wdata,
    input  logic        cpu_release,
    output logic [7:0]  cpu_rdata,
    output logic        cpu_ready,
    output logic [6:0]  cpu_count,
    output logic        cpu_ovf
);
    logic [NUM_BANK-1:0]            bank_cpu, bank_ovf;
    logic [NUM_BANK-1:0][CNT_W-1:0] bank_cnt, bank_rdp;
    logic [NUM_BANK-1:0]            u_wr_v, u_rd_v, u_hand_v;
    logic [NUM_BANK-1:0]            c_wr_v, c_rd_v, c_hand_v;
    logic                           u_owns, c_owns, u_we, c_we;
    logic [BANK_W-1:0]              u_bank, c_bank;
    logic [ADDR_W-1:0]              u_addr, c_addr;

    epbuf_port #(.SIDE_CPU(1'b0)) u_side (
        .clk(clk), .rst_n(rst_n), .ep(usb_ep), .wr(usb_wr), .rd(usb_rd),
        .hand(usb_done), .bank_cpu(bank_cpu), .bank_cnt(bank_cnt),
        .bank_rdp(bank_rdp), .bank_ovf(bank_ovf), .owns(u_owns),
        .sel_bank(u_bank), .sel_cnt(usb_count), .sel_ovf(usb_ovf),
        .wr_v(u_wr_v), .rd_v(u_rd_v), .hand_v(u_hand_v),
        .ram_we(u_we), .ram_addr(u_addr)
    );

    epbuf_port #(.SIDE_CPU(1'b1)) c_side (
        .clk(clk), .rst_n(rst_n), .ep(cpu_ep), .wr(cpu_wr), .rd(cpu_rd),
        .hand(cpu_release), .bank_cpu(bank_cpu), .bank_cnt(bank_cnt),
        .bank_rdp(bank_rdp), .bank_ovf(bank_ovf), .owns(c_owns),
        .sel_bank(c_bank), .sel_cnt(cpu_count), .sel_ovf(cpu_ovf),
        .wr_v(c_wr_v), .rd_v(c_rd_v), .hand_v(c_hand_v),
        .ram_we(c_we), .ram_addr(c_addr)
    );

    for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
        epbuf_bank #(
            .SIZE    (bank_size(b)),
            .RST_CPU (IN_MASK[ep_of_bank(b)])
        ) u_bank_st (
            .clk(clk), .rst_n(rst_n),
            .wr(u_wr_v[b] | c_wr_v[b]),
            .rd(u_rd_v[b] | c_rd_v[b]),
            .hand(u_hand_v[b] | c_hand_v[b]),
            .owner_cpu(bank_cpu[b]), .count(bank_cnt[b]),
            .rdptr(bank_rdp[b]), .ovf(bank_ovf[b])
        );
    end

    epbuf_ram #(.DEPTH(MEM_BYTES), .AW(ADDR_W), .DW(DATA_W)) u_ram (
        .clk(clk),
        .a_we(u_we), .a_addr(u_addr), .a_wdata(usb_wdata), .a_rdata(usb_rdata),
        .b_we(c_we), .b_addr(c_addr), .b_wdata(cpu_wdata), .b_rdata(cpu_rdata)
    );

    // side status outputs
    assign usb_nak   = ~u_owns;
    assign cpu_ready = c_owns;

    assert_sides_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(u_owns && c_owns && (u_bank == c_bank)));
    assert_nak_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        usb_nak |-> !u_we);
    assert_ready_gates_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ready |-> !c_we);
    assert_no_write_on_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        usb_done |-> !u_we);
endmodule

// File: tb/epbuf_top_tb.sv
// Directed bench for the endpoint buffer manager.
module epbuf_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] usb_ep, cpu_ep;
    logic       usb_wr, usb_rd, usb_done, cpu_wr, cpu_rd, cpu_release;
    logic [7:0] usb_wdata, cpu_wdata, usb_rdata, cpu_rdata;
    logic       usb_nak, usb_ovf, cpu_ready, cpu_ovf;
    logic [6:0] usb_count, cpu_count;
    int checks = 0;
    int fails  = 0;
    bit done_flag = 0;

    always #5 clk = ~clk;

    epbuf_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .usb_ep(usb_ep), .usb_wr(usb_wr), .usb_rd(usb_rd), .usb_wdata(usb_wdata),
        .usb_done(usb_done), .usb_rdata(usb_rdata), .usb_nak(usb_nak),
        .usb_count(usb_count), .usb_ovf(usb_ovf),
        .cpu_ep(cpu_ep), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata),
        .cpu_release(cpu_release), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .cpu_count(cpu_count), .cpu_ovf(cpu_ovf)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [7:0] pat(input int ep, input int bank, input int i);
        return 8'(ep * 67 + bank * 29 + i);
    endfunction

    task automatic usb_put(input int ep, input logic [7:0] d);
        usb_ep = 2'(ep); usb_wdata = d; usb_wr = 1'b1; tick(); usb_wr = 1'b0;
    endtask
    task automatic usb_get(input int ep, output logic [7:0] d);
        usb_ep = 2'(ep); usb_rd = 1'b1; tick(); usb_rd = 1'b0; d = usb_rdata;
    endtask
    task automatic usb_fin(input int ep);
        usb_ep = 2'(ep); usb_done = 1'b1; tick(); usb_done = 1'b0; #1;
    endtask
    task automatic cpu_put(input int ep, input logic [7:0] d);
        cpu_ep = 2'(ep); cpu_wdata = d; cpu_wr = 1'b1; tick(); cpu_wr = 1'b0;
    endtask
    task automatic cpu_get(input int ep, output logic [7:0] d);
        cpu_ep = 2'(ep); cpu_rd = 1'b1; tick(); cpu_rd = 1'b0; d = cpu_rdata;
    endtask
    task automatic cpu_rel(input int ep);
        cpu_ep = 2'(ep); cpu_release = 1'b1; tick(); cpu_release = 1'b0; #1;
    endtask
    task automatic look(input int uep, input int cep);
        usb_ep = 2'(uep); cpu_ep = 2'(cep); #1;
    endtask

    // R2: reset ownership and counts
    task automatic t_reset();
        for (int e = 0; e < 4; e++) begin
            look(e, e);
            chk_eq("R2 usb_nak", int'(usb_nak), (e == 3) ? 1 : 0);
            chk_eq("R2 cpu_ready", int'(cpu_ready), (e == 3) ? 1 : 0);
            chk_eq("R2 usb_count", int'(usb_count), 0);
            chk_eq("R2 cpu_count", int'(cpu_count), 0);
        end
    endtask

    // R4 R6 R7 R8 R9: out packet on endpoint 0
    task automatic t_ep0_out();
        logic [7:0] d;
        cpu_put(0, 8'hEE);                       // refused: firmware does not own it (R8)
        for (int i = 0; i < 5; i++) usb_put(0, 8'h10 + 8'(i));
        look(0, 0);
        chk_eq("R8 usb_count after refused cpu write", int'(usb_count), 5);
        usb_fin(0);
        look(0, 0);
        chk_eq("R6 usb_nak after done", int'(usb_nak), 1);
        chk_eq("R4 cpu_ready", int'(cpu_ready), 1);
        chk_eq("R4 cpu_count", int'(cpu_count), 5);
        usb_put(0, 8'h77);                       // refused (R8)
        look(0, 0);
        chk_eq("R8 cpu_count after nak write", int'(cpu_count), 5);
        for (int i = 0; i < 5; i++) begin
            cpu_get(0, d);
            chk_eq("R9 read byte", int'(d), 8'h10 + i);
        end
        cpu_rel(0);
        look(0, 0);
        chk_eq("R6 cpu_ready after release", int'(cpu_ready), 0);
        chk_eq("R6 usb_nak after release", int'(usb_nak), 0);
        chk_eq("R7 count cleared on drain release", int'(usb_count), 0);
    endtask

    // R3: overflow on endpoint 0
    task automatic t_overflow();
        logic [7:0] d;
        for (int i = 0; i < 10; i++) usb_put(0, 8'h40 + 8'(i));
        look(0, 0);
        chk_eq("R3 count saturates", int'(usb_count), 8);
        chk_eq("R3 overflow flag", int'(usb_ovf), 1);
        usb_fin(0);
        look(0, 0);
        chk_eq("R3 cpu_count", int'(cpu_count), 8);
        chk_eq("R3 flag cleared by handover", int'(cpu_ovf), 0);
        for (int i = 0; i < 8; i++) begin
            cpu_get(0, d);
            chk_eq("R3 stored byte", int'(d), 8'h40 + i);
        end
        cpu_rel(0);
    endtask

    // R5 R8 R10: double banking on endpoint 1
    task automatic t_pingpong();
        logic [7:0] d;
        for (int i = 0; i < 3; i++) usb_put(1, 8'hA0 + 8'(i));
        usb_fin(1);
        look(1, 1);
        chk_eq("R5 second bank free", int'(usb_nak), 0);
        chk_eq("R5 second bank empty", int'(usb_count), 0);
        for (int i = 0; i < 4; i++) usb_put(1, 8'hB0 + 8'(i));
        usb_fin(1);
        look(1, 1);
        chk_eq("R5 nak with both banks held", int'(usb_nak), 1);
        usb_put(1, 8'hCC);                        // refused (R8)
        usb_fin(1);                               // refused (R8)
        look(1, 1);
        chk_eq("R10 first bank to firmware", int'(cpu_count), 3);
        for (int i = 0; i < 3; i++) begin
            cpu_get(1, d);
            chk_eq("R10 first bank data", int'(d), 8'hA0 + i);
        end
        cpu_rel(1);
        look(1, 1);
        chk_eq("R5 nak lifted after release", int'(usb_nak), 0);
        chk_eq("R8 refused write left no bytes", int'(usb_count), 0);
        chk_eq("R10 second bank next", int'(cpu_count), 4);
        for (int i = 0; i < 4; i++) begin
            cpu_get(1, d);
            chk_eq("R10 second bank data", int'(d), 8'hB0 + i);
        end
        cpu_rel(1);
        look(1, 1);
        chk_eq("R8 refused done kept ownership", int'(cpu_ready), 0);
    endtask

    // R7 R9: in packet on endpoint 3, firmware fills
    task automatic t_in();
        logic [7:0] d;
        for (int i = 0; i < 6; i++) cpu_put(3, 8'h60 + 8'(i));
        look(3, 3);
        chk_eq("R7 cpu_count after fill", int'(cpu_count), 6);
        cpu_rel(3);
        look(3, 3);
        chk_eq("R6 cpu refused after release", int'(cpu_ready), 0);
        chk_eq("R7 filled count kept", int'(usb_count), 6);
        for (int i = 0; i < 6; i++) begin
            usb_get(3, d);
            chk_eq("R9 usb read byte", int'(d), 8'h60 + i);
        end
        usb_fin(3);
        look(3, 3);
        chk_eq("R7 drained count cleared", int'(cpu_count), 0);
        chk_eq("R6 back with firmware", int'(cpu_ready), 1);
    endtask

    // R11: write in same cycle as done is dropped
    task automatic t_same_cycle();
        logic [7:0] d;
        usb_put(0, 8'h21);
        usb_put(0, 8'h22);
        usb_ep = 2'd0; usb_wdata = 8'h99; usb_wr = 1'b1; usb_done = 1'b1;
        tick();
        usb_wr = 1'b0; usb_done = 1'b0;
        look(0, 0);
        chk_eq("R11 count excludes same-cycle write", int'(cpu_count), 2);
        cpu_get(0, d);
        chk_eq("R11 byte 0", int'(d), 8'h21);
        cpu_ep = 2'd0; cpu_rd = 1'b1; cpu_release = 1'b1;
        tick();
        cpu_rd = 1'b0; cpu_release = 1'b0;
        look(0, 0);
        chk_eq("R11 release done", int'(usb_nak), 0);
    endtask

    // R1: fill every bank, then read all back
    task automatic t_full_map();
        logic [7:0] d;
        for (int i = 0; i < 8; i++)  usb_put(0, pat(0, 0, i));
        usb_fin(0);
        for (int e = 1; e <= 2; e++)
            for (int b = 0; b < 2; b++) begin
                for (int i = 0; i < 64; i++) usb_put(e, pat(e, b, i));
                usb_fin(e);
            end
        for (int i = 0; i < 64; i++) cpu_put(3, pat(3, 0, i));
        cpu_rel(3);
        for (int i = 0; i < 8; i++) begin
            cpu_get(0, d);
            chk_eq("R1 endpoint 0 data", int'(d), int'(pat(0, 0, i)));
        end
        cpu_rel(0);
        for (int e = 1; e <= 2; e++)
            for (int b = 0; b < 2; b++) begin
                look(0, e);
                chk_eq("R1 bank count", int'(cpu_count), 64);
                for (int i = 0; i < 64; i++) begin
                    cpu_get(e, d);
                    chk_eq("R1 double bank data", int'(d), int'(pat(e, b, i)));
                end
                cpu_rel(e);
            end
        for (int i = 0; i < 64; i++) begin
            usb_get(3, d);
            chk_eq("R1 endpoint 3 data", int'(d), int'(pat(3, 0, i)));
        end
        usb_fin(3);
    endtask

    initial begin
        rst_n = 1'b0;
        usb_ep = '0; usb_wr = 0; usb_rd = 0; usb_wdata = '0; usb_done = 0;
        cpu_ep = '0; cpu_wr = 0; cpu_rd = 0; cpu_wdata = '0; cpu_release = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        t_reset();
        t_ep0_out();
        t_overflow();
        t_pingpong();
        t_in();
        t_same_cycle();
        t_full_map();
        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule